// File: doc/BRIEF.md
# Early-Decision Registered Magnitude Comparator

This block compares two unsigned operands, A and B, and reports whether A is strictly greater than B. The operands are captured into registers on every cycle in which the input-valid strobe is high. The greater-than flag is formed from those registers, so it is due one clock edge after the operands are accepted.

A small predictor looks at the top one or two bits of the incoming operands before they are registered. When those bits differ, they settle the comparison on their own. In that case the predictor stores the answer, and the registers that feed the wide comparator on the remaining bits keep their old contents. The wide comparator therefore sees no transitions in that cycle. When the top bits are equal, the lower registers load and the wide comparator supplies the answer.

The parameter `PRE_BITS` selects how many top bits the predictor examines. With uniformly random operands, one bit decides about half of all transfers and two bits decide about three quarters. The lower-register load enable is brought out as a port so that the gating can be observed.

Top module: `early_gt_cmp`

## Requirements
- R1: While the synchronous active-low reset is asserted at a clock edge, every register clears. After reset, `gt_o` reads 0, and `lo_load_o` reads 0 while `in_valid_i` is low.
- R2: When `in_valid_i` is high at a clock edge, `gt_o` after that edge equals 1 exactly when `a_i` > `b_i`, both treated as unsigned `WIDTH`-bit values.
- R3: When `in_valid_i` is low at a clock edge, `gt_o` keeps its previous value, whatever `a_i` and `b_i` carry.
- R4: `lo_load_o` is 1 exactly when `in_valid_i` is 1 and the top `PRE_BITS` bits of `a_i` equal the top `PRE_BITS` bits of `b_i`. When `lo_load_o` is 0, the registers that hold the low `WIDTH-PRE_BITS` operand bits keep their values.
- R5: When the top `PRE_BITS` bits differ, the result follows from those bits alone: `gt_o` is 1 if A's top field is the larger, and 0 otherwise, whatever the lower bits are.
- R6: With `PRE_BITS`=2, a transfer whose most significant bits are equal but whose bits at position `WIDTH-2` differ is decided early. That is, `lo_load_o`=0 and the result is taken from bit `WIDTH-2`.
- R7: Equal operands give `gt_o`=0, and they always load the lower registers.
- R8: Over uniformly random operands, the fraction of valid transfers with `lo_load_o`=0 is near 1/2 for `PRE_BITS`=1 and near 3/4 for `PRE_BITS`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | Accept the operands at this edge |
| a_i | input | WIDTH | Operand A, unsigned |
| b_i | input | WIDTH | Operand B, unsigned |
| gt_o | output | 1 | 1 when the last accepted A exceeds the last accepted B |
| lo_load_o | output | 1 | Load enable of the lower operand registers |

## Verification
`lo_load_o` is combinational from the current inputs. It is due in the same cycle the operands are driven, so the bench samples it a quarter period after driving, before the capturing edge. `gt_o` changes at the edge that accepts the operands. The bench drives on the falling edge, waits for the rising edge, and reads `gt_o` on the following falling edge, one full register stage later. Held-value checks drive new operands with the strobe low and read `gt_o` at that same falling-edge point, after the edge that could have changed it.

// File: rtl/early_gt_pkg.sv
// Package: shared types for the early-decision comparator.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package early_gt_pkg;

    // Early-decision record: whether the top bits settled it, and the answer.
    typedef struct packed {
        logic decided;
        logic value;
    } pred_t;

endpackage

// File: rtl/early_gt_predict.sv
// Module: early_gt_predict
// Examines the top PRE_BITS bits of both operands and decides whether they
// settle A > B on their own.
// Assumes PRE_BITS >= 1 and that it is smaller than the operand width.
module early_gt_predict
    import early_gt_pkg::*;
#(
    parameter int PRE_BITS = 1
) (
    input  logic [PRE_BITS-1:0] a_top_i,
    input  logic [PRE_BITS-1:0] b_top_i,
    output pred_t               pred_o
);

    generate
        if (PRE_BITS == 1) begin : g_one
            // One bit: decided when the bits differ, and true when A has the 1.
            always_comb begin
                pred_o.decided = a_top_i[0] ^ b_top_i[0];
                pred_o.value   = a_top_i[0] & ~b_top_i[0];
            end
        end else begin : g_multi
            // Several bits: decided when the fields differ; the first differing bit gives the answer.
            always_comb begin
                pred_o.decided = (a_top_i != b_top_i);
                pred_o.value   = (a_top_i > b_top_i);
            end
        end
    endgenerate

endmodule

// File: rtl/early_gt_low.sv
// Module: early_gt_low
// Holds the lower operand bits in load-gated registers and compares them.
// Assumes the caller only lowers load_i when the lower result is not needed.
module early_gt_low #(
    parameter int LOW_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LOW_W-1:0] a_lo_i,
    input  logic [LOW_W-1:0] b_lo_i,
    output logic             gt_lo_o
);

    logic [LOW_W-1:0] a_lo_q;
    logic [LOW_W-1:0] b_lo_q;

    // Lower operand registers, loaded only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_lo_q <= '0;
            b_lo_q <= '0;
        end else if (load_i) begin
            a_lo_q <= a_lo_i;
            b_lo_q <= b_lo_i;
        end
    end

    // Wide comparator on the registered lower bits.
    always_comb gt_lo_o = (a_lo_q > b_lo_q);

    // R4: a gated cycle leaves the lower registers untouched.
    p_low_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(a_lo_q) && $stable(b_lo_q)));

endmodule

// File: rtl/early_gt_cmp.sv
// Module: early_gt_cmp (top)
// Registered unsigned A > B. The predictor on the top PRE_BITS bits decides
// early when it can, and the lower registers are then not loaded.
// Assumes 1 <= PRE_BITS <= 2 and PRE_BITS < WIDTH.
module early_gt_cmp
    import early_gt_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int PRE_BITS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             gt_o,
    output logic             lo_load_o
);

    localparam int LOW_W = WIDTH - PRE_BITS;

    pred_t pred_d;
    pred_t pred_q;
    logic  gt_lo;

    early_gt_predict #(.PRE_BITS(PRE_BITS)) u_predict (
        .a_top_i (a_i[WIDTH-1 -: PRE_BITS]),
        .b_top_i (b_i[WIDTH-1 -: PRE_BITS]),
        .pred_o  (pred_d)
    );

    // Lower-register enable: load only for valid transfers that were not decided early.
    always_comb lo_load_o = in_valid_i & ~pred_d.decided;

    // Prediction register: loads on every valid transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) pred_q <= '0;
        else if (in_valid_i) pred_q <= pred_d;
    end

    early_gt_low #(.LOW_W(LOW_W)) u_low (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (lo_load_o),
        .a_lo_i  (a_i[LOW_W-1:0]),
        .b_lo_i  (b_i[LOW_W-1:0]),
        .gt_lo_o (gt_lo)
    );

    // Result selection: the early answer if decided, otherwise the wide comparator.
    always_comb gt_o = pred_q.decided ? pred_q.value : gt_lo;

    // R2: the result one edge after acceptance matches the unsigned comparison.
    p_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (gt_o == ($past(a_i) > $past(b_i))));

    // R3: an idle cycle keeps the result.
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> $stable(gt_o));

    // R4: differing top bits gate the lower registers.
    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && (a_i[WIDTH-1 -: PRE_BITS] != b_i[WIDTH-1 -: PRE_BITS])) |-> !lo_load_o);

    // R7: equal operands always load and give 0.
    p_equal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && (a_i == b_i)) |-> (lo_load_o ##1 !gt_o));

endmodule

// File: tb/early_gt_cmp_bench.sv
// Directed bench for early_gt_cmp: one instance per predictor depth.
module early_gt_cmp_bench;

    localparam int  W      = 16;
    localparam time CLK_P  = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vld = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         gt1, ld1, gt2, ld2;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    early_gt_cmp #(.WIDTH(W), .PRE_BITS(1)) u_early_gt_cmp (
        .clk(clk), .rst_n(rst_n), .in_valid_i(vld), .a_i(a), .b_i(b),
        .gt_o(gt1), .lo_load_o(ld1));

    early_gt_cmp #(.WIDTH(W), .PRE_BITS(2)) u_early_gt_cmp_p2 (
        .clk(clk), .rst_n(rst_n), .in_valid_i(vld), .a_i(a), .b_i(b),
        .gt_o(gt2), .lo_load_o(ld2));

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b (a=%h b=%h)", tag, act, exp, a, b);
        end
    endtask

    function automatic logic top_eq(input logic [W-1:0] x, input logic [W-1:0] y, input int p);
        return (x >> (W - p)) == (y >> (W - p));
    endfunction

    // Drive one transfer, check the enables before the edge and the results after it.
    task automatic xfer(input logic [W-1:0] xa, input logic [W-1:0] xb, input string tag);
        @(negedge clk);
        a = xa; b = xb; vld = 1'b1;
        #(CLK_P/4);
        check(ld1, top_eq(xa, xb, 1), {tag, " R4 load p1"});
        check(ld2, top_eq(xa, xb, 2), {tag, " R4 load p2"});
        @(posedge clk);
        @(negedge clk);
        vld = 1'b0;
        check(gt1, xa > xb, {tag, " R2 gt p1"});
        check(gt2, xa > xb, {tag, " R2 gt p2"});
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0; vld = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(gt1, 1'b0, "R1 gt p1");
        check(gt2, 1'b0, "R1 gt p2");
        check(ld1, 1'b0, "R1 load p1");
        check(ld2, 1'b0, "R1 load p2");
    endtask

    // R5, R6, R7 and undecided cases.
    task automatic t_directed();
        xfer(16'h8000, 16'h7FFF, "R5 msb A");
        xfer(16'h0000, 16'hFFFF, "R2 small A");
        xfer(16'h7FFF, 16'h8000, "R5 msb B");
        xfer(16'h4000, 16'h3FFF, "R6 bit14 A");
        xfer(16'h3FFF, 16'h4000, "R6 bit14 B");
        xfer(16'h1235, 16'h1234, "R2 lsb");
        xfer(16'h5555, 16'h5555, "R7 equal");
        xfer(16'hFFFF, 16'hFFFF, "R7 equal max");
        xfer(16'h0001, 16'h0000, "R2 low one");
    endtask

    // R3: idle cycles with changing operands keep the result.
    task automatic t_hold();
        xfer(16'h9000, 16'h1000, "R3 setup");
        @(negedge clk);
        a = 16'h0000; b = 16'hFFFF; vld = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(gt1, 1'b1, "R3 hold p1");
        check(gt2, 1'b1, "R3 hold p2");
        check(ld1, 1'b0, "R3 no load p1");
        a = 16'h2000; b = 16'h2000;
        @(posedge clk);
        @(negedge clk);
        check(gt2, 1'b1, "R3 hold2 p2");
    endtask

    // R8 and R2: random operands, gating fractions.
    task automatic t_random();
        int g1 = 0;
        int g2 = 0;
        for (int i = 0; i < 1000; i++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = W'($urandom);
            @(negedge clk);
            a = ra; b = rb; vld = 1'b1;
            #(CLK_P/4);
            if (!ld1) g1++;
            if (!ld2) g2++;
            @(posedge clk);
            @(negedge clk);
            vld = 1'b0;
            check(gt1, ra > rb, "R2 random p1");
            check(gt2, ra > rb, "R2 random p2");
        end
        check((g1 > 420) && (g1 < 580), 1'b1, "R8 fraction p1");
        check((g2 > 680) && (g2 < 820), 1'b1, "R8 fraction p2");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        t_reset();
        t_directed();
        t_hold();
        t_random();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule